// File: doc/BRIEF.md
# Daisy-Chained Vectored Interrupt Requester

This block is the device-side end of a three-level, prioritized, vectored interrupt scheme on a shared bus. A peripheral tells it that service is needed and whether interrupts are enabled. The block then samples those two inputs on the rising edge of the interrupt sync strobe. If both are set, it raises the request line for its configured level and holds it until the processor has read the device's vector.

The processor raises the acknowledge line of the winning level and then sends a grant down a daisy chain. A device whose own level's acknowledge was already active when the grant rose takes the grant. It blocks the chain, drives its 8-bit identification vector with an output enable, and asserts vector-valid for as long as the grant stays high. Every other device passes the grant on to the next slot. As a result, the device on the highest acknowledged level that sits closest to the processor wins. When the grant falls, the device releases the data lines and clears its pending request. It can request again only at a later sync edge.

The level (1 to 3) and the vector are parameters. Bus lines are modelled as active-high signals with a separate drive enable. The chain input and output are combinational, so the grant reaches the end of the chain without per-slot delay.

Top module: `irq_requester`

## Requirements
- R1: While reset is low and in the first cycle after it, the request lines, vector output enable and vector-valid are 0, the vector is 0x00, and the outgoing grant equals the incoming grant.
- R2: At a clock edge where the sync input is 1 and was 0 at the previous edge, the pending request is set if and only if both the service flag and the enable bit are 1. Only request bit LEVEL-1 of the 3-bit request output (bit 0 = lowest level) reflects it, from the cycle after that edge. The other two bits stay 0.
- R3: Changes of the service flag or the enable bit while sync is held high or low have no effect on the request output. Only a new rising sync edge samples them.
- R4: The grant is taken only if the request is pending and the acknowledge bit LEVEL-1 was 1 at the clock edge before the edge where the incoming grant is first seen high. An acknowledge arriving together with the grant, or on another level, does not lead to capture.
- R5: A device that has not taken the grant copies the incoming grant to the outgoing grant in the same cycle, including a grant that was already high when the device became qualified.
- R6: From the cycle after capture, for as long as the incoming grant is high, the outgoing grant is 0, the vector enable and vector-valid are 1, and the vector equals the VECTOR parameter. The outgoing grant is also 0 in the capture cycle itself.
- R7: One cycle after the incoming grant falls with the vector driven, vector enable, vector-valid and the request output are 0. The request stays 0 until a later rising sync edge samples service and enable set again.
- R8: Whenever the vector enable is 0 the vector output is 0x00.
- R9: In a chain of two devices that both request, the upstream device wins on its own level while the downstream device sees no grant. When only the downstream device's level is acknowledged, the upstream device passes the grant and the downstream device wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| need_svc | input | 1 | Device needs service |
| dev_en | input | 1 | Device interrupt enable bit |
| sync | input | 1 | Interrupt sync strobe, sampled on its rising edge |
| ack | input | 3 | Level acknowledge lines, bit 0 lowest level |
| grant_in | input | 1 | Daisy-chain grant from the processor side |
| irq_req | output | 3 | Request lines, only bit LEVEL-1 used |
| grant_out | output | 1 | Daisy-chain grant to the next slot |
| vec | output | 8 | Identification vector |
| vec_oe | output | 1 | Drive enable for the vector |
| vec_valid | output | 1 | Vector-valid strobe |

## Verification
On every cycle, the assertions check several properties. They confirm that the outgoing grant is never high while the incoming one is low or while the vector is driven. They check that the vector is held while the grant stays high and is released with the request one cycle after the grant falls. They also check that the vector is zero when undriven, that foreign request bits stay clear, and that capture only follows a pending request with the grant high. Only the bench scenarios can show the sampling behaviour: that the request follows service and enable only at a rising sync edge, and that an acknowledge arriving together with the grant or on another level is refused. The bench also shows the two-device chain, where the first qualified slot wins on its level.

// File: rtl/irq_requester.sv
module irq_requester #(
  parameter int LEVEL = 1,
  parameter logic [7:0] VECTOR = 8'h5A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       need_svc,
  input  logic       dev_en,
  input  logic       sync,
  input  logic [2:0] ack,
  input  logic       grant_in,
  output logic [2:0] irq_req,
  output logic       grant_out,
  output logic [7:0] vec,
  output logic       vec_oe,
  output logic       vec_valid
);

  localparam logic [2:0] OWN_MASK = 3'b001 << (LEVEL - 1);

  logic sync_q;
  logic grant_q;
  logic pending;
  logic qual;
  logic won;

  wire sync_rise  = sync & ~sync_q;
  wire grant_rise = grant_in & ~grant_q;
  wire block      = won | (qual & ~grant_q);
  wire release_v  = won & ~grant_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= 1'b0;
      grant_q <= 1'b0;
      pending <= 1'b0;
      qual    <= 1'b0;
      won     <= 1'b0;
    end else begin
      sync_q  <= sync;
      grant_q <= grant_in;
      qual    <= pending & ack[LEVEL-1] & ~release_v;
      if (release_v)
        pending <= 1'b0;
      else if (sync_rise && need_svc && dev_en)
        pending <= 1'b1;
      if (release_v)
        won <= 1'b0;
      else if (grant_rise && qual)
        won <= 1'b1;
    end
  end

  assign irq_req   = pending ? OWN_MASK : 3'b000;
  assign grant_out = grant_in & ~block;
  assign vec_oe    = won;
  assign vec_valid = won;
  assign vec       = won ? VECTOR : 8'h00;

endmodule

// File: rtl/irq_requester_chk.sv
module irq_requester_chk #(
  parameter int LEVEL = 1,
  parameter logic [7:0] VECTOR = 8'h5A
) (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] irq_req,
  input logic       grant_in,
  input logic       grant_out,
  input logic [7:0] vec,
  input logic       vec_oe,
  input logic       vec_valid
);

  localparam logic [2:0] OWN_MASK = 3'b001 << (LEVEL - 1);

  a_r2_own_bit_only: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req & ~OWN_MASK) == 3'b000);

  a_r5_no_grant_no_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_in |-> !grant_out);

  a_r6_chain_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> !grant_out);

  a_r6_vector_value: assert property (@(posedge clk) disable iff (!rst_n)
    vec_oe |-> (vec == VECTOR) && vec_valid);

  a_r6_hold_while_granted: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && grant_in) |=> vec_valid);

  a_r7_release_and_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !grant_in) |=> (!vec_valid && irq_req == 3'b000));

  a_r8_idle_vector_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_oe |-> vec == 8'h00);

  a_r4_capture_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_valid) |-> ($past(irq_req) == OWN_MASK) && $past(grant_in));

endmodule

bind irq_requester irq_requester_chk #(.LEVEL(LEVEL), .VECTOR(VECTOR)) u_chk (.*);

// File: tb/tb_irq_requester.sv
`timescale 1ns/1ps
module tb_irq_requester;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic need_a = 1'b0, en_a = 1'b0, need_b = 1'b0, en_b = 1'b0;
  logic sync = 1'b0;
  logic [2:0] ack = 3'b000;
  logic grant = 1'b0;
  logic [2:0] req_a, req_b;
  logic go_a, go_b, oe_a, oe_b, vv_a, vv_b;
  logic [7:0] vec_a, vec_b;
  int total = 0;
  int bad = 0;

  localparam logic [7:0] VA = 8'h3C;
  localparam logic [7:0] VB = 8'hC3;

  always #5 clk = ~clk;

  irq_requester #(.LEVEL(1), .VECTOR(VA)) dut (
    .clk(clk), .rst_n(rst_n), .need_svc(need_a), .dev_en(en_a), .sync(sync),
    .ack(ack), .grant_in(grant), .irq_req(req_a), .grant_out(go_a),
    .vec(vec_a), .vec_oe(oe_a), .vec_valid(vv_a));

  irq_requester #(.LEVEL(3), .VECTOR(VB)) dut2 (
    .clk(clk), .rst_n(rst_n), .need_svc(need_b), .dev_en(en_b), .sync(sync),
    .ack(ack), .grant_in(go_a), .irq_req(req_b), .grant_out(go_b),
    .vec(vec_b), .vec_oe(oe_b), .vec_valid(vv_b));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic drv();
    @(negedge clk);
  endtask

  task automatic pulse_sync();
    drv(); sync = 1'b1;
    tick();
    drv(); sync = 1'b0;
    tick();
  endtask

  task automatic drop_grant();
    drv(); grant = 1'b0; ack = 3'b000;
    tick();
  endtask

  initial begin
    #1500us;
    total++; bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    grant = 1'b1;
    repeat (3) tick();
    chk("R1 req", {26'd0, req_a, req_b}, 32'd0);
    chk("R1 vec", {14'd0, oe_a, vv_a, vec_a, oe_b, vv_b, vec_b}, 32'd0);
    chk("R1 pass", {30'd0, go_a, go_b}, 32'd3);
    drv(); grant = 1'b0; rst_n = 1'b1;
    tick();
    chk("R1 after reset", {26'd0, req_a, req_b}, 32'd0);

    for (int i = 0; i < 4; i++) begin
      drv(); need_a = i[1]; en_a = i[0]; sync = 1'b1;
      tick();
      chk("R2 sample", {29'd0, req_a}, (i == 3) ? 32'd1 : 32'd0);
      drv(); sync = 1'b0; ack = 3'b001;
      tick();
      drv(); grant = 1'b1;
      #1;
      chk("R6 capture-cycle block", {31'd0, go_a}, (i == 3) ? 32'd0 : 32'd1);
      tick();
      for (int h = 0; h < 3; h++) begin
        if (i == 3) begin
          chk("R6 vector", {22'd0, oe_a, vv_a, vec_a}, {22'd0, 2'b11, VA});
          chk("R6 blocked", {31'd0, go_a}, 32'd0);
        end else begin
          chk("R5 pass", {31'd0, go_a}, 32'd1);
          chk("R8 idle vec", {22'd0, oe_a, vv_a, vec_a}, 32'd0);
        end
        tick();
      end
      drop_grant();
      chk("R7 released", {21'd0, oe_a, vv_a, vec_a, req_a}, 32'd0);
    end

    drv(); need_a = 1'b0; en_a = 1'b1; sync = 1'b1;
    tick();
    drv(); need_a = 1'b1;
    tick(); tick();
    chk("R3 held sync", {29'd0, req_a}, 32'd0);
    drv(); sync = 1'b0;
    tick();
    drv(); en_a = 1'b0;
    tick(); drv(); en_a = 1'b1; tick();
    chk("R3 low sync", {29'd0, req_a}, 32'd0);
    pulse_sync();
    chk("R3 new edge", {29'd0, req_a}, 32'd1);

    drv(); ack = 3'b001; grant = 1'b1;
    tick();
    chk("R4 ack with grant", {30'd0, vv_a, go_a}, 32'd1);
    tick();
    chk("R5 late qual passes", {30'd0, vv_a, go_a}, 32'd1);
    drop_grant();
    chk("R4 still pending", {29'd0, req_a}, 32'd1);

    drv(); ack = 3'b100;
    tick();
    drv(); grant = 1'b1;
    tick(); tick();
    chk("R4 wrong level", {30'd0, vv_a, go_a}, 32'd1);
    drop_grant();

    drv(); ack = 3'b001;
    tick();
    drv(); grant = 1'b1;
    tick();
    chk("R6 won", {31'd0, vv_a}, 32'd1);
    drop_grant();
    repeat (3) tick();
    chk("R7 no re-request", {29'd0, req_a}, 32'd0);
    pulse_sync();
    chk("R7 re-request", {29'd0, req_a}, 32'd1);

    drv(); need_b = 1'b1; en_b = 1'b1;
    pulse_sync();
    chk("R9 both pending", {26'd0, req_a, req_b}, {26'd0, 3'b001, 3'b100});
    drv(); ack = 3'b100;
    tick();
    drv(); grant = 1'b1;
    tick();
    chk("R9 downstream wins", {21'd0, vv_a, go_a, go_b, vv_b, oe_b, vec_b},
        {21'd0, 1'b0, 1'b1, 1'b0, 2'b11, VB});
    drop_grant();
    chk("R9 upstream kept", {26'd0, req_a, req_b}, {26'd0, 3'b001, 3'b000});
    pulse_sync();
    chk("R9 downstream again", {29'd0, req_b}, 32'd4);
    drv(); ack = 3'b001;
    tick();
    drv(); grant = 1'b1;
    tick();
    chk("R9 upstream wins", {19'd0, vv_a, vec_a, go_a, vv_b, go_b, oe_b},
        {19'd0, 1'b1, VA, 4'b0000});
    drop_grant();
    chk("R9 downstream waiting", {26'd0, req_a, req_b}, {26'd0, 3'b000, 3'b100});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule